// File: doc/BRIEF.md
# USB Device State Tracker

This block follows the device framework state of a USB peripheral controller. It keeps a 3-bit state code that a status register can expose. It reacts to single-cycle event pulses from the surrounding logic:

- a software reset;
- a bus reset;
- a suspend detect and a resume;
- completed address and configuration requests, each with a flag that says whether the requested value was zero.

The asynchronous hardware reset input also returns the block to its initial state. Each time the state code changes, the block raises a one-cycle change pulse.

The block also watches the raw VBUS pin. The level passes through a synchronizer, then through a stability filter clocked by a periodic sample strobe. A new level is accepted only after it has been seen on several consecutive strobes. The accepted level is reported, and any change of it sets a sticky change flag. The flag is cleared by a dedicated clear pulse.

Top module: `usb_dev_state_tracker`

## Requirements
- R1: While the hardware reset is low, and after it is released, the state code is Powered (000). The change pulse is 0, the VBUS level is 0 and the VBUS change flag is 0.
- R2: A software reset pulse sets the state to Powered (000) in the next cycle, from any state.
- R3: A bus reset pulse without a software reset sets the state to Default (001) from any state, including the suspended states.
- R4: An address request acts only in Default (001) or Address (010). With a nonzero address it leads to Address. With a zero address it leads to Default. In Powered, Configured and the suspended states it leaves the state unchanged.
- R5: A configuration request acts only in Address (010) or Configured (011). With a nonzero value it leads to Configured. With a zero value it leads to Address. In every other state it leaves the state unchanged.
- R6: A suspend pulse in an awake state moves the state to the suspended code: bit 2 set, with bits 1:0 holding the awake state's bits 1:0. In a suspended state the suspend pulse has no effect.
- R7: A resume pulse in a suspended state returns the state to the awake code held in bits 1:0. A resume pulse in an awake state has no effect. Address and configuration requests have no effect while suspended.
- R8: When several pulses arrive in one cycle, the priority is: software reset, then bus reset, then suspend/resume, then the configuration request, then the address request.
- R9: The change output is 1 in exactly those cycles where the state code differs from its value in the previous cycle.
- R10: The VBUS level output changes only after the same synchronized value has been sampled on STABLE_SAMPLES consecutive strobes (default 3). A pulse that is seen on fewer strobes is ignored.
- R11: Every change of the VBUS level output sets the change flag. The flag stays set until a clear pulse arrives. If a level change and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_reset_i | input | 1 | Software reset pulse |
| bus_reset_i | input | 1 | Bus reset detected pulse |
| suspend_i | input | 1 | Suspend detected pulse |
| resume_i | input | 1 | Resume detected pulse |
| set_addr_i | input | 1 | Address request completed pulse |
| addr_zero_i | input | 1 | The completed address request had value zero |
| set_cfg_i | input | 1 | Configuration request completed pulse |
| cfg_zero_i | input | 1 | The completed configuration request had value zero |
| vbus_i | input | 1 | Raw asynchronous VBUS level |
| vbus_chg_clr_i | input | 1 | Clear pulse for the VBUS change flag |
| dev_state_o | output | 3 | Current device state code |
| state_chg_o | output | 1 | One-cycle pulse on a state code change |
| vbus_level_o | output | 1 | Filtered VBUS level |
| vbus_chg_o | output | 1 | Sticky VBUS change flag |

## Verification
The bench builds the block with a strobe divider of 4 and the default run length of 3 samples and 2 synchronizer stages.

The short strobe period keeps the filter latency at a few tens of cycles. A VBUS glitch lasting exactly one strobe period can therefore be placed so that it is caught on only one strobe. This tests the rejection side of R10 as well as its acceptance side, along with the timing of setting and clearing the flag.

The state rules are tested by a walk through every state, including the ignored requests and simultaneous pulses.

// File: rtl/usb_dst_pkg.sv
package usb_dst_pkg;

  localparam int STATE_W = 3;

  // bit 2 marks suspension; bits 1:0 keep the awake state
  typedef enum logic [STATE_W-1:0] {
    ST_POWERED  = 3'b000,
    ST_DEFAULT  = 3'b001,
    ST_ADDRESS  = 3'b010,
    ST_CONFIG   = 3'b011,
    ST_SUSP_PWR = 3'b100,
    ST_SUSP_DEF = 3'b101,
    ST_SUSP_ADR = 3'b110,
    ST_SUSP_CFG = 3'b111
  } dev_state_t;

  typedef struct packed {
    logic sw_reset;
    logic bus_reset;
    logic suspend;
    logic resume;
    logic set_addr;
    logic addr_zero;
    logic set_cfg;
    logic cfg_zero;
  } dev_event_t;

endpackage

// File: rtl/usb_dst_sync.sv
module usb_dst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/usb_dst_vbus_filter.sv
module usb_dst_vbus_filter #(
  parameter int STROBE_DIV     = 16,
  parameter int STABLE_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_sync_i,
  input  logic chg_clr_i,
  output logic level_o,
  output logic chg_o
);

  localparam int CNT_W = (STROBE_DIV > 1) ? $clog2(STROBE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_DIV - 1);

  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      strobe;
  logic [STABLE_SAMPLES-1:0] hist_q, hist_d;
  logic                      level_q, level_d;
  logic                      chg_q, chg_d;
  logic                      run_high, run_low;

  // sample strobe generator
  assign strobe = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (strobe) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  // sample history shifted once per strobe
  always_comb begin
    hist_d = hist_q;
    if (strobe) hist_d = {hist_q[STABLE_SAMPLES-2:0], vbus_sync_i};
  end

  assign run_high = &hist_q;
  assign run_low  = ~|hist_q;

  always_comb begin
    level_d = level_q;
    if (run_high)     level_d = 1'b1;
    else if (run_low) level_d = 1'b0;
  end

  always_comb begin
    chg_d = chg_q;
    if (chg_clr_i)          chg_d = 1'b0;
    if (level_d != level_q) chg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      hist_q  <= '0;
      level_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      hist_q  <= hist_d;
      level_q <= level_d;
      chg_q   <= chg_d;
    end
  end

  assign level_o = level_q;
  assign chg_o   = chg_q;

  // R10: an accepted level is backed by a full run of matching samples
  p_level_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (hist_q == {STABLE_SAMPLES{level_q}}));

  // R11: each accepted level change raises the flag
  p_flag_on_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> chg_q);

  // R11: the flag holds until cleared
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !chg_clr_i) |=> chg_q);

  initial begin
    a_params_r10: assert (STABLE_SAMPLES >= 2 && STROBE_DIV >= 2);
  end

endmodule

// File: rtl/usb_dst_state_fsm.sv
module usb_dst_state_fsm
  import usb_dst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  dev_event_t          ev_i,
  output logic [STATE_W-1:0]  state_o,
  output logic                chg_o
);

  dev_state_t cur_q, nxt;
  logic       chg_q;
  logic       awake_addr_ok, awake_cfg_ok;

  assign awake_addr_ok = (cur_q == ST_DEFAULT) || (cur_q == ST_ADDRESS);
  assign awake_cfg_ok  = (cur_q == ST_ADDRESS) || (cur_q == ST_CONFIG);

  always_comb begin
    nxt = cur_q;
    if (ev_i.sw_reset) begin
      nxt = ST_POWERED;
    end else if (ev_i.bus_reset) begin
      nxt = ST_DEFAULT;
    end else if (cur_q[2]) begin
      if (ev_i.resume) nxt = dev_state_t'({1'b0, cur_q[1:0]});
    end else if (ev_i.suspend) begin
      nxt = dev_state_t'({1'b1, cur_q[1:0]});
    end else if (ev_i.set_cfg && awake_cfg_ok) begin
      nxt = ev_i.cfg_zero ? ST_ADDRESS : ST_CONFIG;
    end else if (ev_i.set_addr && awake_addr_ok) begin
      nxt = ev_i.addr_zero ? ST_DEFAULT : ST_ADDRESS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= ST_POWERED;
      chg_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      chg_q <= (nxt != cur_q);
    end
  end

  assign state_o = cur_q;
  assign chg_o   = chg_q;

  // R2: software reset lands in Powered
  p_swrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.sw_reset |=> (state_o == ST_POWERED));

  // R3: bus reset lands in Default
  p_busrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.bus_reset && !ev_i.sw_reset) |=> (state_o == ST_DEFAULT));

  // R7: resume restores the awake code kept in the low bits
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[2] && ev_i.resume && !ev_i.sw_reset && !ev_i.bus_reset)
      |=> (state_o == {1'b0, $past(state_o[1:0])}));

  // R9: change pulse marks exactly the cycles with a new code
  p_chg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o == (state_o != $past(state_o)));

endmodule

// File: rtl/usb_dev_state_tracker.sv
module usb_dev_state_tracker
  import usb_dst_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STROBE_DIV     = 16,
  parameter int STABLE_SAMPLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset_i,
  input  logic       bus_reset_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  input  logic       set_addr_i,
  input  logic       addr_zero_i,
  input  logic       set_cfg_i,
  input  logic       cfg_zero_i,
  input  logic       vbus_i,
  input  logic       vbus_chg_clr_i,
  output logic [2:0] dev_state_o,
  output logic       state_chg_o,
  output logic       vbus_level_o,
  output logic       vbus_chg_o
);

  logic       rst_sync_n;
  logic       vbus_sync;
  dev_event_t ev;

  // reset asserts at once, releases on a clock edge
  usb_dst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  usb_dst_sync #(.STAGES(SYNC_STAGES)) u_vbus_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (vbus_i),
    .q_o   (vbus_sync)
  );

  usb_dst_vbus_filter #(
    .STROBE_DIV     (STROBE_DIV),
    .STABLE_SAMPLES (STABLE_SAMPLES)
  ) u_vbus_filter (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .vbus_sync_i (vbus_sync),
    .chg_clr_i   (vbus_chg_clr_i),
    .level_o     (vbus_level_o),
    .chg_o       (vbus_chg_o)
  );

  always_comb begin
    ev.sw_reset  = sw_reset_i;
    ev.bus_reset = bus_reset_i;
    ev.suspend   = suspend_i;
    ev.resume    = resume_i;
    ev.set_addr  = set_addr_i;
    ev.addr_zero = addr_zero_i;
    ev.set_cfg   = set_cfg_i;
    ev.cfg_zero  = cfg_zero_i;
  end

  usb_dst_state_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ev_i    (ev),
    .state_o (dev_state_o),
    .chg_o   (state_chg_o)
  );

  // R1: hardware reset holds the state at Powered
  p_hwrst_powered_r1: assert property (@(posedge clk)
    !rst_n |=> (dev_state_o == 3'b000 && !state_chg_o));

endmodule

// File: tb/usb_dev_state_tracker_tb.sv
module usb_dev_state_tracker_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_reset, bus_reset, suspend, resume_p;
  logic set_addr, addr_zero, set_cfg, cfg_zero;
  logic vbus, vbus_clr;
  logic [2:0] dev_state;
  logic state_chg, vbus_level, vbus_chg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_dev_state_tracker #(
    .SYNC_STAGES(2), .STROBE_DIV(4), .STABLE_SAMPLES(3)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sw_reset_i(sw_reset), .bus_reset_i(bus_reset),
    .suspend_i(suspend), .resume_i(resume_p),
    .set_addr_i(set_addr), .addr_zero_i(addr_zero),
    .set_cfg_i(set_cfg), .cfg_zero_i(cfg_zero),
    .vbus_i(vbus), .vbus_chg_clr_i(vbus_clr),
    .dev_state_o(dev_state), .state_chg_o(state_chg),
    .vbus_level_o(vbus_level), .vbus_chg_o(vbus_chg)
  );

  // {sw, br, sus, res, sa, sa_zero, sc, sc_zero, exp_state[2:0], exp_chg}
  localparam int NV = 30;
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_1000_000_0, // R4 address ignored in Powered
    12'b0000_0010_000_0, // R5 config ignored in Powered
    12'b0100_0000_001_1, // R3 bus reset -> Default
    12'b0000_0010_001_0, // R5 config ignored in Default
    12'b0000_1100_001_0, // R4 zero address stays Default
    12'b0000_1000_010_1, // R4 nonzero address -> Address
    12'b0000_1000_010_0, // R4 repeat keeps Address
    12'b0000_0011_010_0, // R5 zero config keeps Address
    12'b0000_0010_011_1, // R5 nonzero config -> Configured
    12'b0000_1000_011_0, // R4 address ignored in Configured
    12'b0000_0010_011_0, // R5 repeat keeps Configured
    12'b0010_0000_111_1, // R6 suspend from Configured
    12'b0000_1010_111_0, // R7 requests ignored while suspended
    12'b0010_0000_111_0, // R6 suspend ignored while suspended
    12'b0001_0000_011_1, // R7 resume -> Configured
    12'b0001_0000_011_0, // R7 resume ignored when awake
    12'b0000_0011_010_1, // R5 zero config -> Address
    12'b0000_1100_001_1, // R4 zero address -> Default
    12'b0010_0000_101_1, // R6 suspend from Default
    12'b0100_0000_001_1, // R3 bus reset from suspended
    12'b0000_1000_010_1, // R4 address again
    12'b1100_0000_000_1, // R8 sw reset beats bus reset (R2)
    12'b0110_0000_001_1, // R8 bus reset beats suspend
    12'b0000_1000_010_1, // R4 address
    12'b0010_0000_110_1, // R6 suspend from Address
    12'b0011_0000_010_1, // R8 resume while suspended
    12'b1010_0000_000_1, // R2 sw reset beats suspend
    12'b0010_0000_100_1, // R6 suspend from Powered
    12'b0001_0000_000_1, // R7 resume -> Powered
    12'b0000_0000_000_0  // R9 idle, no pulse
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [7:0] e);
    {sw_reset, bus_reset, suspend, resume_p, set_addr, addr_zero, set_cfg, cfg_zero} = e;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive_ev(8'h00);
    vbus = 1'b0;
    vbus_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", dev_state, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 state after reset", {dev_state, state_chg}, 4'b0000);
    chk("R1 vbus after reset", {vbus_level, vbus_chg}, 2'b00);

    // table walk: apply at negedge, sample at next negedge
    for (int i = 0; i < NV; i++) begin
      drive_ev(VEC[i][11:4]);
      @(negedge clk);
      chk($sformatf("R4/R5/R6/R7/R8/R9 vector %0d", i),
          {dev_state, state_chg}, VEC[i][3:0]);
    end
    drive_ev(8'h00);

    // R2: software reset from Configured
    drive_ev(8'b0100_0000); @(negedge clk);
    drive_ev(8'b0000_1000); @(negedge clk);
    drive_ev(8'b0000_0010); @(negedge clk);
    drive_ev(8'b1000_0000); @(negedge clk);
    chk("R2 sw reset from Configured", {dev_state, state_chg}, 4'b0001);
    drive_ev(8'h00);

    // R1: hardware reset mid-run, async assertion
    drive_ev(8'b0100_0000); @(negedge clk);
    drive_ev(8'h00);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R1 async reset", dev_state, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: rising VBUS not taken early, then accepted
    vbus = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 level not yet accepted", vbus_level, 1'b0);
    repeat (30) @(negedge clk);
    chk("R10 level accepted high", vbus_level, 1'b1);
    chk("R11 flag set on rise", vbus_chg, 1'b1);
    vbus_clr = 1'b1; @(negedge clk); vbus_clr = 1'b0;
    chk("R11 flag cleared", vbus_chg, 1'b0);
    @(negedge clk);
    chk("R11 flag stays clear", vbus_chg, 1'b0);

    // R10: glitch lasting one strobe period is rejected
    vbus = 1'b0;
    repeat (4) @(negedge clk);
    vbus = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 glitch ignored, level", vbus_level, 1'b1);
    chk("R10 glitch ignored, flag", vbus_chg, 1'b0);

    // R10/R11: falling VBUS accepted, flag held across time
    vbus = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 level accepted low", vbus_level, 1'b0);
    chk("R11 flag set on fall", vbus_chg, 1'b1);
    repeat (10) @(negedge clk);
    chk("R11 flag held", vbus_chg, 1'b1);

    finish_run();
  end

endmodule